// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block watches the running calendar time of a real-time clock and raises an alarm interrupt when the time reaches a programmed point. It holds four BCD alarm fields: seconds, minutes, hours, and a day field. The day field is compared either with the day of the week or with the date of the month. Each field has its own mask bit that removes it from the comparison. With masks alone, software can choose an alarm every second, every minute, every hour, every day, or once per week or month.

An external timekeeping counter supplies the current time as BCD bytes and a one-cycle strobe. The strobe is issued once per second, after the new time has been loaded. The comparison is made only in the cycle of that strobe. A match sets a sticky flag. The active-low interrupt output is asserted while both the flag and the interrupt enable are set. A small byte-wide register port gives software access to the alarm fields, the enable and the flag. Reading the flag clears it.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset, `irq_n` is 1, and every register address 0 to 5 reads 0x00.
- R2: The following register layout applies:
  - Addresses 0, 1 and 2 hold the seconds, minutes and hours alarms. Bit 7 of each is its mask, and bits 6:0 hold the BCD value.
  - Address 3 holds the day alarm. Bit 7 is its mask. Bit 6 selects date of month when 1 and day of week when 0. Bits 5:0 hold the BCD value.
  - Addresses 0 to 3 read back the full byte last written.
  - Address 4 bit 0 is the interrupt enable, and its other bits read 0.
- R3: A matching time without the once-per-second strobe never sets the flag.
- R4: On a strobe, a field that is not masked matches only when its stored value equals the current value. The alarm matches when every unmasked field matches.
- R5: With all four mask bits set, every strobe sets the flag.
- R6: With the day mask clear, the day value is compared with `now_mday` when bit 6 of address 3 is 1, and with `now_wday` when it is 0. The other day input has no effect.
- R7: A match on a strobe sets the flag at the following clock edge, whatever the enable. `irq_n` is 0 exactly when the flag and the enable are both 1.
- R8: A read of address 5 returns the flag in bit 0, with the other bits 0, and clears the flag at that edge. A match in the same cycle as the read leaves the flag set.
- R9: Writes to address 5, 6 or 7 change no register, no flag and not `irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second, after the new time is loaded |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD 00-23 |
| now_wday | input | 8 | Current day of week, BCD 1-7 |
| now_mday | input | 8 | Current date of month, BCD 01-31 |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the address |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The assertions assume the following about the inputs:
- `tick_1hz` is a single-cycle pulse.
- The current-time bytes are stable in the strobe cycle.
- Read and write strobes are never raised together.

The bench drives the time only at falling edges and holds it through each strobe. It pulses the strobe for exactly one cycle and issues bus operations one at a time. It keeps the time inputs within legal BCD ranges. The two day inputs are always driven to different values, so that a wrong day selection shows up as a wrong match.

// File: rtl/tam_pkg.sv
package tam_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int NFIELD  = 4;
  localparam int MASK_B  = 7;
  localparam int DSEL_B  = 6;

  localparam logic [ADDR_W-1:0] ADR_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DAY  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CTL  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd5;

  // One alarm field: hit when masked or when the stored value equals now.
  function automatic logic field_hit(input logic masked,
                                     input logic [BYTE_W-1:0] alarm_val,
                                     input logic [BYTE_W-1:0] now_val);
    return masked || (alarm_val == now_val);
  endfunction
endpackage

// File: rtl/tam_regs.sv
module tam_regs
  import tam_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_we,
  input  logic                         bus_re,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [BYTE_W-1:0]            bus_wdata,
  input  logic                         flag,
  output logic [BYTE_W-1:0]            bus_rdata,
  output logic [NFIELD-1:0][BYTE_W-1:0] alm,
  output logic                         en,
  output logic                         status_rd
);
  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (bus_we && bus_addr == ADDR_W'(i)) q <= bus_wdata;
    end
    assign alm[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else if (bus_we && bus_addr == ADR_CTL) en <= bus_wdata[0];
  end

  assign status_rd = bus_re && (bus_addr == ADR_STAT);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_SEC, ADR_MIN, ADR_HOUR, ADR_DAY: bus_rdata = alm[bus_addr[1:0]];
      ADR_CTL:  bus_rdata = {{(BYTE_W-1){1'b0}}, en};
      ADR_STAT: bus_rdata = {{(BYTE_W-1){1'b0}}, flag};
      default:  bus_rdata = '0;
    endcase
  end

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADR_CTL) |=> (en == $past(bus_wdata[0]))); // R2
  AST_UNUSED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr > ADR_CTL) |=> ($stable(alm) && $stable(en))); // R9
endmodule

// File: rtl/tam_match.sv
module tam_match
  import tam_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [NFIELD-1:0][BYTE_W-1:0] alm,
  input  logic [BYTE_W-1:0]             now_sec,
  input  logic [BYTE_W-1:0]             now_min,
  input  logic [BYTE_W-1:0]             now_hour,
  input  logic [BYTE_W-1:0]             now_wday,
  input  logic [BYTE_W-1:0]             now_mday,
  output logic                          hit,
  output logic                          tick_hit
);
  logic [NFIELD-1:0]             fhit;
  logic [BYTE_W-1:0]             day_now;
  logic [NFIELD-1:0][BYTE_W-1:0] now_v;
  logic [NFIELD-1:0][BYTE_W-1:0] alm_v;

  assign day_now = alm[3][DSEL_B] ? now_mday : now_wday;
  assign now_v   = {day_now, now_hour, now_min, now_sec};

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    // Day field value has two fewer bits (mask plus selector above it).
    if (i == NFIELD - 1) begin : g_day
      assign alm_v[i] = {2'b00, alm[i][DSEL_B-1:0]};
    end else begin : g_time
      assign alm_v[i] = {1'b0, alm[i][MASK_B-1:0]};
    end
    assign fhit[i] = field_hit(alm[i][MASK_B], alm_v[i], now_v[i]);
  end

  assign hit      = &fhit;
  assign tick_hit = tick && hit;

  AST_DATE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!alm[3][MASK_B] && alm[3][DSEL_B] &&
     now_mday != {2'b00, alm[3][DSEL_B-1:0]}) |-> !hit); // R6
  AST_WDAY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!alm[3][MASK_B] && !alm[3][DSEL_B] &&
     now_wday != {2'b00, alm[3][DSEL_B-1:0]}) |-> !hit); // R6
endmodule

// File: rtl/tam_flag.sv
module tam_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tick_hit,
  input  logic status_rd,
  input  logic en,
  output logic flag,
  output logic irq_n
);
  // A new match outranks the clear caused by a read in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (tick_hit)  flag <= 1'b1;
    else if (status_rd) flag <= 1'b0;
  end

  assign irq_n = ~(flag & en);

  AST_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick_hit)); // R7
  AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_hit |=> flag); // R8
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !tick_hit) |=> !flag); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !status_rd) |=> $stable(flag)); // R3
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tam_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [7:0]        now_sec,
  input  logic [7:0]        now_min,
  input  logic [7:0]        now_hour,
  input  logic [7:0]        now_wday,
  input  logic [7:0]        now_mday,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_n
);
  logic [NFIELD-1:0][BYTE_W-1:0] alm;
  logic en, flag, status_rd, hit, tick_hit;

  tam_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flag(flag),
    .bus_rdata(bus_rdata), .alm(alm), .en(en), .status_rd(status_rd)
  );

  tam_match u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .alm(alm),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_wday(now_wday), .now_mday(now_mday),
    .hit(hit), .tick_hit(tick_hit)
  );

  tam_flag u_flag (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .tick_hit(tick_hit),
    .status_rd(status_rd), .en(en), .flag(flag), .irq_n(irq_n)
  );

  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && alm[0][MASK_B] && alm[1][MASK_B] && alm[2][MASK_B] &&
     alm[3][MASK_B]) |=> flag); // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> (en && flag)); // R7
endmodule

// File: tb/sim_tod_alarm_match.sv
`timescale 1ns/100ps
module sim_tod_alarm_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 1'b0;
  logic [7:0] now_sec = 0, now_min = 0, now_hour = 0, now_wday = 8'h01, now_mday = 8'h01;
  logic bus_we = 0, bus_re = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic irq_n;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  tod_alarm_match u0 (.*);

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1;
    #1 d = bus_rdata;
    @(negedge clk); bus_re = 0;
  endtask

  // Drive the time and pulse the strobe; returns at the negedge after it.
  task automatic tick(input int s, input int m, input int h, input int wd, input int md);
    @(negedge clk);
    now_sec = to_bcd(s); now_min = to_bcd(m); now_hour = to_bcd(h);
    now_wday = to_bcd(wd); now_mday = to_bcd(md);
    tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    // Alarm: 30 s, 15 min, 12 h, day value 5; mismatches use +1
    int as = 30, am = 15, ah = 12, ad = 5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(irq_n == 1, "R1 irq_n", irq_n, 1);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check(d == 0, "R1 reset read", d, 0);
    end

    // R2 readback
    wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'hFF); wr(3, 8'h5A); wr(4, 8'hFF);
    rd(0, d); check(d == 8'hA5, "R2 sec", d, 8'hA5);
    rd(1, d); check(d == 8'h3C, "R2 min", d, 8'h3C);
    rd(2, d); check(d == 8'hFF, "R2 hour", d, 8'hFF);
    rd(3, d); check(d == 8'h5A, "R2 day", d, 8'h5A);
    rd(4, d); check(d == 8'h01, "R2 ctl", d, 8'h01);

    // R3 matching time without strobe: all masked, no tick
    wr(0, 8'h80); wr(1, 8'h80); wr(2, 8'h80); wr(3, 8'h80);
    repeat (5) @(negedge clk);
    check(irq_n == 1, "R3 irq_n no tick", irq_n, 1);
    rd(5, d); check(d == 0, "R3 flag no tick", d, 0);

    // R4/R5/R6 sweep: 16 masks x 2 selectors x 16 match patterns
    for (int sel = 0; sel < 2; sel++) begin
      for (int mk = 0; mk < 16; mk++) begin
        wr(0, {mk[0], 7'(to_bcd(as))});
        wr(1, {mk[1], 7'(to_bcd(am))});
        wr(2, {mk[2], 7'(to_bcd(ah))});
        wr(3, {mk[3], sel[0], 6'(to_bcd(ad))});
        for (int p = 0; p < 16; p++) begin
          int s, m, h, wd, md, sd;
          bit exp;
          s = p[0] ? as : as + 1;
          m = p[1] ? am : am + 1;
          h = p[2] ? ah : ah + 1;
          sd = p[3] ? ad : ad + 1;         // selected day source
          // unselected source takes the opposite value
          if (sel == 1) begin md = sd; wd = p[3] ? ad + 1 : ad; end
          else begin wd = sd; md = p[3] ? ad + 1 : ad; end
          exp = (mk[0] || s == as) && (mk[1] || m == am) &&
                (mk[2] || h == ah) && (mk[3] || sd == ad);
          tick(s, m, h, wd, md);
          check(irq_n == !exp, mk == 15 ? "R5 irq every tick" : "R4 irq on match",
                irq_n, !exp);
          rd(5, d);
          check(d == {7'b0, exp}, sel ? "R6 date flag" : "R6 wday flag", d, {7'b0, exp});
          check(irq_n == 1, "R8 irq after clear", irq_n, 1);
        end
      end
    end

    // R7 flag set while disabled; irq follows enable
    wr(0, 8'h80); wr(1, 8'h80); wr(2, 8'h80); wr(3, 8'h80);
    wr(4, 8'h00);
    tick(0, 0, 0, 1, 1);
    check(irq_n == 1, "R7 disabled irq_n", irq_n, 1);
    wr(4, 8'h01);
    check(irq_n == 0, "R7 enable asserts irq", irq_n, 0);

    // R9 writes to 5..7 ignored
    wr(5, 8'h00); wr(6, 8'hFF); wr(7, 8'hFF);
    check(irq_n == 0, "R9 irq kept", irq_n, 0);
    rd(0, d); check(d == 8'h80, "R9 sec kept", d, 8'h80);
    rd(3, d); check(d == 8'h80, "R9 day kept", d, 8'h80);
    rd(4, d); check(d == 8'h01, "R9 ctl kept", d, 8'h01);
    rd(5, d); check(d == 8'h01, "R9 flag kept", d, 8'h01);
    check(irq_n == 1, "R8 read clears", irq_n, 1);

    // R8 match and read in the same cycle: match wins
    @(negedge clk);
    tick_1hz = 1; bus_addr = 5; bus_re = 1;
    #1 d = bus_rdata;
    check(d == 0, "R8 collision old flag", d, 0);
    @(negedge clk); tick_1hz = 0; bus_re = 0;
    check(irq_n == 0, "R8 collision irq", irq_n, 0);
    rd(5, d); check(d == 8'h01, "R8 collision flag kept", d, 8'h01);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule